// File: doc/BRIEF.md
# Speculative Load Fault Tracker

This block screens a speculative load, one that must not raise an exception, in the cycle it is issued. It forms the effective address from a base register value plus either an index register value or a sign-carrying immediate. From the access size it finds two kinds of fault: a misaligned memory address and a misaligned destination register. Neither fault traps. Each is recorded as a poison flag on the destination register. There is one flag bank for the integer registers and one for the float registers.

A load with no fault of its own inherits poison from its source registers. A poisoned result suppresses the load, and the block tells the pipeline whether the load may go ahead. When logging is switched on by the control inputs, every screened load also claims the lowest free slot in a small record table. The slot holds a description of the access and its effective address, which later recovery logic reads through a read port. The block does not access memory itself.

Top module: `spec_load_guard`

## Requirements
- R1: The effective address is `base_val_i + idx_val_i` when `idx_en_i` is 1, and `base_val_i + imm_i` otherwise (modulo 2^ADDR_W).
- R2: The size codes are 0 byte, 1 halfword, 2 word, 3 double, 4 quad. An address fault occurs when the address is not a multiple of 1, 2, 4, 8 or 16 bytes, in that order. Byte accesses never fault.
- R3: A register fault occurs for size 3 when `tgt_sel_i` is odd, and for size 4 when `tgt_sel_i` is not a multiple of 4.
- R4: Any fault raises `fault_o`, keeps `proceed_o` at 1 and sets the destination's poison flag in the bank that `fp_i` selects.
- R5: With no fault, the destination flag becomes the OR of the base register's flag and, only when `idx_en_i` is 1, the index register's flag. The flags are read from the bank that `fp_i` selects. If the result is 1, `proceed_o` is 0.
- R6: With no fault and clean sources, the destination flag is cleared and `proceed_o` is 1.
- R7: The integer and float banks are independent. Poison in one bank never affects loads that use the other.
- R8: Logging is active only when both `log_valid_i` and `log_en_i` are 1. When logging is inactive, `logged_o` and `no_slot_o` stay 0 and no record changes.
- R9: An active logging load takes the lowest-numbered slot with a clear valid bit, among slots below `min(slot_cnt_i, NUM_SLOTS)`. The slot index appears on `slot_o` together with `logged_o`.
- R10: A written record reads back as {valid=1 [16], addr_valid=1 [15], fp [14], align_err [13], reg_err [12], size [11:9], slot [8:6], target [5:0]}. `rd_addr_o` holds the effective address.
- R11: If logging is active and no slot is free, `no_slot_o` is 1 for that response and no record is written.
- R12: Results appear one cycle after `req_i`, qualified by `rsp_valid_o`. After reset all flags are clear, all records read as zero, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Load to screen this cycle |
| base_sel_i | input | RIDX_W | Base register number |
| base_val_i | input | ADDR_W | Base register value |
| idx_en_i | input | 1 | Use the index register instead of the immediate |
| idx_sel_i | input | RIDX_W | Index register number |
| idx_val_i | input | ADDR_W | Index register value |
| imm_i | input | ADDR_W | Immediate displacement |
| tgt_sel_i | input | RIDX_W | Destination register number |
| size_i | input | 3 | Access size code |
| fp_i | input | 1 | Destination and sources are float registers |
| log_valid_i | input | 1 | Logging control valid |
| log_en_i | input | 1 | Logging enable |
| slot_cnt_i | input | CNT_W | Number of implemented record slots |
| rd_slot_i | input | SIDX_W | Record read index |
| rsp_valid_o | output | 1 | Response valid |
| proceed_o | output | 1 | Load may be performed |
| fault_o | output | 1 | Address or register fault detected |
| logged_o | output | 1 | Record written |
| no_slot_o | output | 1 | Logging active but the table was full |
| slot_o | output | SIDX_W | Slot written |
| rd_rec_o | output | REC_W | Record at `rd_slot_i` |
| rd_addr_o | output | ADDR_W | Address at `rd_slot_i` |

## Verification
The assertions assume that `size_i` holds one of the five defined codes whenever `req_i` is 1. They also assume that `slot_cnt_i` never exceeds the table depth, and that the control inputs hold steady from one request into its response cycle. The stimulus keeps to these limits: it uses only codes 0 to 4 and slot counts of 3, 5 and 8, and it changes the logging controls only between requests. Each control setting is held for as long as its loads are in flight.

// File: rtl/slg_pkg.sv
package slg_pkg;
  typedef enum logic [2:0] {
    SZ_B = 3'd0,
    SZ_H = 3'd1,
    SZ_W = 3'd2,
    SZ_D = 3'd3,
    SZ_Q = 3'd4
  } acc_size_e;
endpackage

// File: rtl/slg_align_chk.sv
module slg_align_chk import slg_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RIDX_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [RIDX_W-1:0] tgt_i,
  output logic              mis_addr_o,
  output logic              mis_reg_o
);
  always_comb begin
    mis_addr_o = 1'b0;
    mis_reg_o  = 1'b0;
    unique case (size_i)
      SZ_H:    mis_addr_o = addr_i[0];
      SZ_W:    mis_addr_o = |addr_i[1:0];
      SZ_D: begin
        mis_addr_o = |addr_i[2:0];
        mis_reg_o  = tgt_i[0];
      end
      SZ_Q: begin
        mis_addr_o = |addr_i[3:0];
        mis_reg_o  = |tgt_i[1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slg_flag_bank.sv
module slg_flag_bank #(
  parameter int unsigned NUM_REGS = 64,
  localparam int unsigned RIDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RIDX_W-1:0] rd_a_i,
  input  logic [RIDX_W-1:0] rd_b_i,
  output logic              flag_a_o,
  output logic              flag_b_o,
  input  logic              wr_en_i,
  input  logic [RIDX_W-1:0] wr_sel_i,
  input  logic              wr_val_i
);
  logic [NUM_REGS-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (wr_en_i) flags_q[wr_sel_i] <= wr_val_i;
  end

  assign flag_a_o = flags_q[rd_a_i];
  assign flag_b_o = flags_q[rd_b_i];
endmodule

// File: rtl/slg_log_table.sv
module slg_log_table #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned RIDX_W    = 6,
  localparam int unsigned SIDX_W = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int unsigned REC_W  = 8 + SIDX_W + RIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [CNT_W-1:0]  slot_cnt_i,
  input  logic [RIDX_W-1:0] tgt_i,
  input  logic [2:0]        size_i,
  input  logic              fp_i,
  input  logic              align_err_i,
  input  logic              reg_err_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              grant_o,
  output logic [SIDX_W-1:0] grant_idx_o,
  input  logic [SIDX_W-1:0] rd_slot_i,
  output logic [REC_W-1:0]  rd_rec_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [REC_W-1:0]  rec_q  [NUM_SLOTS];
  logic [ADDR_W-1:0] addr_q [NUM_SLOTS];
  logic [CNT_W-1:0]  lim;
  logic              found;
  logic [SIDX_W-1:0] pick;

  assign lim = (slot_cnt_i > CNT_W'(NUM_SLOTS)) ? CNT_W'(NUM_SLOTS) : slot_cnt_i;

  // descending scan so the lowest free index wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (CNT_W'(i) < lim && !rec_q[i][REC_W-1]) begin
        found = 1'b1;
        pick  = SIDX_W'(i);
      end
    end
  end

  assign grant_o     = wr_req_i && found;
  assign grant_idx_o = pick;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rec_q[g]  <= '0;
        addr_q[g] <= '0;
      end else if (grant_o && pick == SIDX_W'(g)) begin
        rec_q[g]  <= {2'b11, fp_i, align_err_i, reg_err_i, size_i, SIDX_W'(g), tgt_i};
        addr_q[g] <= addr_i;
      end
    end
  end

  assign rd_rec_o  = rec_q[rd_slot_i];
  assign rd_addr_o = addr_q[rd_slot_i];
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard import slg_pkg::*; #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_REGS  = 64,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned RIDX_W = $clog2(NUM_REGS),
  localparam int unsigned SIDX_W = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int unsigned REC_W  = 8 + SIDX_W + RIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [RIDX_W-1:0] base_sel_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic              idx_en_i,
  input  logic [RIDX_W-1:0] idx_sel_i,
  input  logic [ADDR_W-1:0] idx_val_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [RIDX_W-1:0] tgt_sel_i,
  input  logic [2:0]        size_i,
  input  logic              fp_i,
  input  logic              log_valid_i,
  input  logic              log_en_i,
  input  logic [CNT_W-1:0]  slot_cnt_i,
  input  logic [SIDX_W-1:0] rd_slot_i,
  output logic              rsp_valid_o,
  output logic              proceed_o,
  output logic              fault_o,
  output logic              logged_o,
  output logic              no_slot_o,
  output logic [SIDX_W-1:0] slot_o,
  output logic [REC_W-1:0]  rd_rec_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [ADDR_W-1:0] eff_addr;
  logic              mis_addr, mis_reg, any_fault;
  logic [1:0]        fa_base, fa_idx;
  logic              inherit, new_flag, go;
  logic              log_on, grant;
  logic [SIDX_W-1:0] grant_idx;

  assign eff_addr = base_val_i + (idx_en_i ? idx_val_i : imm_i);

  slg_align_chk #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_align (
    .addr_i    (eff_addr),
    .size_i    (size_i),
    .tgt_i     (tgt_sel_i),
    .mis_addr_o(mis_addr),
    .mis_reg_o (mis_reg)
  );

  // bank 0: integer, bank 1: float
  for (genvar b = 0; b < 2; b++) begin : g_bank
    slg_flag_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_a_i  (base_sel_i),
      .rd_b_i  (idx_sel_i),
      .flag_a_o(fa_base[b]),
      .flag_b_o(fa_idx[b]),
      .wr_en_i (req_i && (fp_i == 1'(b))),
      .wr_sel_i(tgt_sel_i),
      .wr_val_i(new_flag)
    );
  end

  assign any_fault = mis_addr | mis_reg;
  assign inherit   = fa_base[fp_i] | (idx_en_i & fa_idx[fp_i]);
  assign new_flag  = any_fault | inherit;
  assign go        = any_fault | ~inherit;
  assign log_on    = log_valid_i & log_en_i;

  slg_log_table #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (req_i && log_on),
    .slot_cnt_i (slot_cnt_i),
    .tgt_i      (tgt_sel_i),
    .size_i     (size_i),
    .fp_i       (fp_i),
    .align_err_i(mis_addr),
    .reg_err_i  (mis_reg),
    .addr_i     (eff_addr),
    .grant_o    (grant),
    .grant_idx_o(grant_idx),
    .rd_slot_i  (rd_slot_i),
    .rd_rec_o   (rd_rec_o),
    .rd_addr_o  (rd_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      proceed_o   <= 1'b0;
      fault_o     <= 1'b0;
      logged_o    <= 1'b0;
      no_slot_o   <= 1'b0;
      slot_o      <= '0;
    end else begin
      rsp_valid_o <= req_i;
      proceed_o   <= req_i & go;
      fault_o     <= req_i & any_fault;
      logged_o    <= grant;
      no_slot_o   <= req_i & log_on & ~grant;
      slot_o      <= grant ? grant_idx : '0;
    end
  end
endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
  parameter int unsigned SIDX_W = 3,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        size_i,
  input logic              log_valid_i,
  input logic              log_en_i,
  input logic [CNT_W-1:0]  slot_cnt_i,
  input logic              rsp_valid_o,
  input logic              proceed_o,
  input logic              fault_o,
  input logic              logged_o,
  input logic              no_slot_o,
  input logic [SIDX_W-1:0] slot_o
);
  p_byte_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && $past(size_i) == 3'd0 |-> !fault_o);

  p_fault_proceeds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o |-> proceed_o);

  p_log_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !($past(log_valid_i) && $past(log_en_i)) |-> !logged_o && !no_slot_o);

  p_slot_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logged_o |-> CNT_W'(slot_o) < $past(slot_cnt_i));

  p_full_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({logged_o, no_slot_o}));

  p_zero_slots_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && $past(log_valid_i) && $past(log_en_i) && $past(slot_cnt_i) == '0
    |-> no_slot_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !proceed_o && !fault_o && !logged_o && !no_slot_o);
endmodule

bind spec_load_guard slg_checker #(.SIDX_W(SIDX_W), .CNT_W(CNT_W)) u_slg_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .size_i     (size_i),
  .log_valid_i(log_valid_i),
  .log_en_i   (log_en_i),
  .slot_cnt_i (slot_cnt_i),
  .rsp_valid_o(rsp_valid_o),
  .proceed_o  (proceed_o),
  .fault_o    (fault_o),
  .logged_o   (logged_o),
  .no_slot_o  (no_slot_o),
  .slot_o     (slot_o)
);

// File: tb/tb_spec_load_guard.sv
`timescale 1ns/1ps
module tb_spec_load_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  base_sel = '0, idx_sel = '0, tgt_sel = '0;
  logic [31:0] base_val = '0, idx_val = '0, imm = '0;
  logic        idx_en = 1'b0, fp = 1'b0;
  logic [2:0]  size = '0;
  logic        lv = 1'b0, le = 1'b0;
  logic [3:0]  cnt = 4'd8;
  logic [2:0]  rd_slot = '0;
  logic        rsp_valid, proceed, fault, logged, no_slot;
  logic [2:0]  slot;
  logic [16:0] rd_rec;
  logic [31:0] rd_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_int = '0, m_fp = '0;
  logic [16:0] m_rec [8];
  logic [31:0] m_addr [8];
  logic [6:0]  exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  spec_load_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .base_sel_i(base_sel), .base_val_i(base_val), .idx_en_i(idx_en),
    .idx_sel_i(idx_sel), .idx_val_i(idx_val), .imm_i(imm),
    .tgt_sel_i(tgt_sel), .size_i(size), .fp_i(fp),
    .log_valid_i(lv), .log_en_i(le), .slot_cnt_i(cnt), .rd_slot_i(rd_slot),
    .rsp_valid_o(rsp_valid), .proceed_o(proceed), .fault_o(fault),
    .logged_o(logged), .no_slot_o(no_slot), .slot_o(slot),
    .rd_rec_o(rd_rec), .rd_addr_o(rd_addr)
  );

  task automatic chk(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] bs, input logic [31:0] bv, input logic ie,
                       input logic [5:0] is, input logic [31:0] iv, input logic [31:0] im,
                       input logic [5:0] tg, input logic [2:0] sz, input logic f, input string r);
    logic [31:0] ea;
    logic ma, mr, inh, flt, go, lg, ns, found;
    logic [2:0] sl;
    logic [63:0] fl;
    @(negedge clk);
    req = 1; base_sel = bs; base_val = bv; idx_en = ie; idx_sel = is;
    idx_val = iv; imm = im; tgt_sel = tg; size = sz; fp = f;
    ea = bv + (ie ? iv : im);
    ma = 0; mr = 0;
    case (sz)
      3'd1: ma = ea[0];
      3'd2: ma = |ea[1:0];
      3'd3: begin ma = |ea[2:0]; mr = tg[0]; end
      3'd4: begin ma = |ea[3:0]; mr = |tg[1:0]; end
      default: ;
    endcase
    fl = f ? m_fp : m_int;
    inh = fl[bs] | (ie & fl[is]);
    flt = ma | mr;
    go = flt | ~inh;
    fl[tg] = flt | inh;
    if (f) m_fp = fl; else m_int = fl;
    lg = 0; ns = 0; sl = 0; found = 0;
    if (lv && le) begin
      for (int i = 0; i < 8; i++)
        if (!found && i < int'(cnt) && !m_rec[i][16]) begin found = 1; sl = 3'(i); end
      if (found) begin
        lg = 1;
        m_rec[sl] = {2'b11, f, ma, mr, sz, sl, tg};
        m_addr[sl] = ea;
      end else ns = 1;
    end
    exp_q.push_back({go, flt, ns, lg, sl});
    tag_q.push_back(r);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); req = 0; end
  endtask

  task automatic check_records(string r);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_slot = 3'(i);
      #1;
      chk(rd_rec == m_rec[i], r, $sformatf("record %0d", i), rd_rec, m_rec[i]);
      if (m_rec[i][16])
        chk(rd_addr == m_addr[i], "R1", $sformatf("address %0d", i), rd_addr, m_addr[i]);
    end
  endtask

  // monitor: pop expected item for every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [6:0] e;
      string r;
      if (exp_q.size() == 0) chk(0, "R12", "unexpected response", 1, 0);
      else begin
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        chk(proceed == e[6], r, "proceed", proceed, e[6]);
        chk(fault == e[5], r, "fault", fault, e[5]);
        chk(no_slot == e[4], r, "no_slot", no_slot, e[4]);
        chk(logged == e[3], r, "logged", logged, e[3]);
        if (e[3]) chk(slot == e[2:0], r, "slot", slot, e[2:0]);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      chk(0, "WATCHDOG", "run did not finish", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_rec[i] = '0; m_addr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk({rsp_valid, proceed, fault, logged, no_slot} == 5'b0, "R12", "outputs after reset",
        {rsp_valid, proceed, fault, logged, no_slot}, 0);
    check_records("R12");

    // R2 address alignment by size
    issue(0, 32'h1001, 0, 0, 0, 0, 1, 3'd0, 0, "R2");
    issue(0, 32'h1001, 0, 0, 0, 0, 2, 3'd1, 0, "R2");
    issue(0, 32'h1002, 0, 0, 0, 0, 3, 3'd1, 0, "R2");
    issue(0, 32'h1002, 0, 0, 0, 0, 4, 3'd2, 0, "R2");
    issue(0, 32'h1000, 1, 5, 32'h4, 0, 6, 3'd2, 0, "R1");
    issue(0, 32'h1004, 0, 0, 0, 0, 8, 3'd3, 0, "R2");
    issue(0, 32'h1008, 0, 0, 0, 0, 10, 3'd3, 0, "R2");
    issue(0, 32'h1008, 0, 0, 0, 0, 12, 3'd4, 0, "R2");
    issue(0, 32'h1010, 0, 0, 0, 0, 16, 3'd4, 0, "R2");
    // R3 register alignment
    issue(0, 32'h1008, 0, 0, 0, 0, 11, 3'd3, 0, "R3");
    issue(0, 32'h1010, 0, 0, 0, 0, 18, 3'd4, 0, "R3");
    issue(0, 32'h1010, 0, 0, 0, 0, 20, 3'd4, 0, "R3");
    // R5 propagation from sources
    issue(2, 32'h1000, 0, 0, 0, 0, 30, 3'd2, 0, "R5");
    issue(0, 32'h1000, 1, 4, 32'h8, 0, 31, 3'd2, 0, "R5");
    issue(0, 32'h1000, 0, 4, 32'h8, 32'h8, 32, 3'd2, 0, "R5");
    // R6 clean load clears poison
    issue(0, 32'h1000, 0, 0, 0, 0, 2, 3'd2, 0, "R6");
    issue(2, 32'h1000, 0, 0, 0, 0, 33, 3'd2, 0, "R6");
    // R4 fault with poisoned base still proceeds, poisons target
    issue(30, 32'h1001, 0, 0, 0, 0, 34, 3'd1, 0, "R4");
    issue(34, 32'h1000, 0, 0, 0, 0, 35, 3'd2, 0, "R4");
    // R7 bank separation
    issue(40, 32'h1001, 0, 0, 0, 0, 40, 3'd1, 1, "R7");
    issue(40, 32'h1000, 0, 0, 0, 0, 41, 3'd2, 0, "R7");
    issue(40, 32'h1000, 0, 0, 0, 0, 42, 3'd2, 1, "R7");
    idle(2);

    // R8 logging gate
    lv = 1; le = 0;
    issue(0, 32'h2000, 0, 0, 0, 0, 44, 3'd2, 0, "R8");
    idle(1);
    lv = 0; le = 1;
    issue(0, 32'h2000, 0, 0, 0, 0, 45, 3'd2, 0, "R8");
    idle(2);
    check_records("R8");

    // R9, R10, R11 allocation within a count of 3
    lv = 1; le = 1; cnt = 4'd3;
    issue(0, 32'h2000, 1, 6, 32'h30, 0, 46, 3'd3, 0, "R9");
    issue(0, 32'h2000, 0, 0, 0, 32'hFFFF_FFF8, 47, 3'd2, 0, "R9");
    issue(48, 32'h2004, 0, 0, 0, 0, 50, 3'd4, 1, "R10");
    issue(0, 32'h2100, 0, 0, 0, 0, 52, 3'd2, 0, "R11");
    idle(2);
    check_records("R11");
    cnt = 4'd5;
    issue(0, 32'h2201, 0, 0, 0, 0, 53, 3'd1, 0, "R9");
    idle(2);
    check_records("R10");

    chk(exp_q.size() == 0, "R12", "responses outstanding", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule